// File: doc/BRIEF.md
# Row-Maskable Latin-Square Majority Decoder

This block corrects a data word protected by an orthogonal-Latin-square code in which some parity rows may have been switched off after test. Only the check bits of enabled rows are kept in storage, and they are packed into the low end of the stored check vector. The block takes the raw data word, the packed check bits and the per-row enable mask. It puts each packed check bit back at the code position it belongs to, then decodes every data bit in a single step.

Each data bit is decoded from a pool of votes. One vote is the stored bit itself. Each parity group adds a second vote, and that vote counts only when its row is enabled. A parity vote is the row's check bit XORed with the other data bits of that row. The voter compares the number of ones against half of the votes actually cast. A disabled row therefore neither adds a vote nor moves the threshold.

The data word holds M×M bits and there are 2T groups of M check rows each. The corrected word leaves through an output register. A synthesis-time parameter can remove that register.

Top module: `olsd_decoder`

## Requirements
- R1: With every row enabled and error-free inputs (`chk_stored` equal to the full check vector of `data_in`), `data_out` equals `data_in` one clock after the inputs are applied.
- R2: With every row enabled, any combination of at most T flipped bits across `data_in` and `chk_stored` is corrected exactly.
- R3: Expansion rule: the k-th bit of `chk_stored` (counting from bit 0) belongs to the k-th set bit of `row_en` (counting from bit 0). Stored bits at positions at or above the count of enabled rows have no effect on `data_out`.
- R4: With `row_en` all zero, `data_out` equals `data_in` whatever `chk_stored` holds.
- R5: Vote rule for each data bit:
  - The votes are the raw bit plus the n estimates from enabled rows. Data bit i sits at row r=i/M, column c=i%M.
  - Check index g*M+l is line l of group g. Group 0 uses line r, group 1 uses line c, and group g≥2 uses line (r*(g-1)+c) mod M.
  - An estimate is the check bit XORed with the other data bits of its line.
  - The output bit is 1 when twice the count of ones exceeds n+1, and 0 when it falls below n+1.
  - On a tie the output keeps the raw bit.
- R6: While `rst_n` is low, `data_out` is zero. The reset acts without waiting for a clock edge.
- R7: `data_out` changes only at a rising clock edge: new inputs appear at the output after exactly one edge.
- R8: When the inputs are held unchanged across clock edges, `data_out` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | M*M | Raw data word as read from storage |
| chk_stored | input | 2*T*M | Packed check bits of the enabled rows, low end first |
| row_en | input | 2*T*M | One enable bit per parity row, index g*M+l |
| data_out | output | M*M | Corrected data word, registered |

## Verification
The bench builds the block with M=5 and T=2. This gives a 25-bit word and four parity groups, so two-error correction can be exercised with all 20 rows on.

Reduced masks reach the interesting voter sizes:
- A single enabled group casts two votes, so every disagreement ends in a tie.
- Two enabled groups give a clean three-vote majority.
- Sparse masks put the packed check bits far from their full positions.

Random masks and flip patterns are compared against a bench-side model of the vote rule. The rule was written from the requirements alone.

// File: rtl/olsd_pkg.sv
package olsd_pkg;

  // Line of group g that contains data bit i of an m x m square (m prime).
  function automatic int ols_line(input int i, input int g, input int m);
    int r;
    int c;
    r = i / m;
    c = i % m;
    if (g == 0) return r;
    else if (g == 1) return c;
    else return (r * (g - 1) + c) % m;
  endfunction

endpackage

// File: rtl/olsd_expand.sv
// Switch network: returns packed check bits to their full code positions.
module olsd_expand #(
  parameter int NC = 20
) (
  input  logic [NC-1:0] chk_packed,
  input  logic [NC-1:0] row_en,
  output logic [NC-1:0] chk_full
);
  localparam int CW = $clog2(NC + 1);

  // pre[j] = number of enabled rows below index j
  logic [CW-1:0] pre [NC+1];

  assign pre[0] = '0;

  genvar j;
  generate
    for (j = 0; j < NC; j++) begin : g_slot
      assign pre[j+1] = pre[j] + CW'(row_en[j]);
      assign chk_full[j] = row_en[j] & chk_packed[pre[j]];
    end
  endgenerate
endmodule

// File: rtl/olsd_estimates.sv
// Builds one gated parity estimate per data bit per check group.
module olsd_estimates #(
  parameter int M = 5,
  parameter int T = 2
) (
  input  logic [M*M-1:0]       data_in,
  input  logic [2*T*M-1:0]     chk_full,
  input  logic [2*T*M-1:0]     row_en,
  output logic [M*M*2*T-1:0]   est,
  output logic [M*M*2*T-1:0]   est_en
);
  localparam int K  = M * M;
  localparam int NE = 2 * T;
  localparam int NC = NE * M;

  function automatic logic [K-1:0] line_mask(input int idx);
    logic [K-1:0] msk;
    msk = '0;
    for (int b = 0; b < K; b++)
      if (olsd_pkg::ols_line(b, idx / M, M) == idx % M) msk[b] = 1'b1;
    return msk;
  endfunction

  logic [NC-1:0] line_par;

  genvar j, i, g;
  generate
    for (j = 0; j < NC; j++) begin : g_par
      localparam logic [K-1:0] MSK = line_mask(j);
      assign line_par[j] = ^(data_in & MSK);
    end

    for (i = 0; i < K; i++) begin : g_bit
      for (g = 0; g < NE; g++) begin : g_grp
        localparam int IDX = g * M + olsd_pkg::ols_line(i, g, M);
        // line parity already holds data_in[i]; XOR it back out
        assign est[i*NE+g]    = row_en[IDX] & (chk_full[IDX] ^ line_par[IDX] ^ data_in[i]);
        assign est_en[i*NE+g] = row_en[IDX];
      end
    end
  endgenerate
endmodule

// File: rtl/olsd_voter.sv
// Threshold voter whose majority point follows the number of enabled estimates.
module olsd_voter #(
  parameter int NE = 4
) (
  input  logic          raw,
  input  logic [NE-1:0] est,
  input  logic [NE-1:0] est_en,
  output logic          dec
);
  localparam int VW = $clog2(NE + 2);

  logic [VW-1:0] n_en;
  logic [VW-1:0] n_one;
  logic [VW:0]   twice_one;
  logic [VW:0]   votes;

  always_comb begin
    n_en  = '0;
    n_one = VW'(raw);
    for (int g = 0; g < NE; g++) begin
      n_en  = n_en  + VW'(est_en[g]);
      n_one = n_one + VW'(est[g]);
    end
    twice_one = {n_one, 1'b0};
    votes     = {1'b0, n_en} + (VW+1)'(1);
    if (twice_one > votes)      dec = 1'b1;
    else if (twice_one < votes) dec = 1'b0;
    else                        dec = raw;
  end
endmodule

// File: rtl/olsd_decoder.sv
module olsd_decoder #(
  parameter int M       = 5,
  parameter int T       = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [M*M-1:0]     data_in,
  input  logic [2*T*M-1:0]   chk_stored,
  input  logic [2*T*M-1:0]   row_en,
  output logic [M*M-1:0]     data_out
);
  localparam int K  = M * M;
  localparam int NE = 2 * T;
  localparam int NC = NE * M;

  logic [NC-1:0]   chk_full;
  logic [K*NE-1:0] est;
  logic [K*NE-1:0] est_en;
  logic [K-1:0]    dec_nxt;

  olsd_expand #(.NC(NC)) u_expand (
    .chk_packed (chk_stored),
    .row_en     (row_en),
    .chk_full   (chk_full)
  );

  olsd_estimates #(.M(M), .T(T)) u_est (
    .data_in  (data_in),
    .chk_full (chk_full),
    .row_en   (row_en),
    .est      (est),
    .est_en   (est_en)
  );

  genvar i;
  generate
    for (i = 0; i < K; i++) begin : g_vote
      olsd_voter #(.NE(NE)) u_voter (
        .raw    (data_in[i]),
        .est    (est[i*NE +: NE]),
        .est_en (est_en[i*NE +: NE]),
        .dec    (dec_nxt[i])
      );
    end

    if (REG_OUT) begin : g_reg
      logic [K-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= dec_nxt;
      end
      assign data_out = out_q;
    end else begin : g_comb
      assign data_out = dec_nxt;
    end
  endgenerate
endmodule

// File: rtl/olsd_decoder_chk.sv
module olsd_decoder_chk #(
  parameter int M       = 5,
  parameter int T       = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [M*M-1:0]     data_in,
  input logic [2*T*M-1:0]   chk_stored,
  input logic [2*T*M-1:0]   row_en,
  input logic [M*M-1:0]     data_out
);
  localparam int K  = M * M;
  localparam int NC = 2 * T * M;

  function automatic logic [NC-1:0] full_code(input logic [K-1:0] d);
    logic [NC-1:0] c;
    c = '0;
    for (int j = 0; j < NC; j++)
      for (int b = 0; b < K; b++)
        if (olsd_pkg::ols_line(b, j / M, M) == j % M) c[j] = c[j] ^ d[b];
    return c;
  endfunction

  generate
    if (REG_OUT) begin : g_chk
      // R6
      always @(negedge clk)
        if (!rst_n) reset_zero_chk: assert (data_out == '0);

      // R4
      all_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en == '0) |=> (data_out == $past(data_in)));

      // R1
      clean_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_en == '1) && (chk_stored == full_code(data_in))) |=> (data_out == $past(data_in)));

      // R8
      hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(data_in) && $stable(chk_stored) && $stable(row_en)) |=> $stable(data_out));
    end
  endgenerate
endmodule

bind olsd_decoder olsd_decoder_chk #(.M(M), .T(T), .REG_OUT(REG_OUT)) u_olsd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_in    (data_in),
  .chk_stored (chk_stored),
  .row_en     (row_en),
  .data_out   (data_out)
);

// File: tb/olsd_decoder_test.sv
`timescale 1ns/1ps
module olsd_decoder_test;
  localparam int M  = 5;
  localparam int T  = 2;
  localparam int K  = M * M;
  localparam int NC = 2 * T * M;
  localparam int NV = 10;

  logic          clk;
  logic          rst_n;
  logic [K-1:0]  data_in;
  logic [NC-1:0] chk_stored;
  logic [NC-1:0] row_en;
  logic [K-1:0]  data_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  olsd_decoder #(.M(M), .T(T), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .chk_stored(chk_stored), .row_en(row_en), .data_out(data_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Stimulus table: word, data flips, full-position check flips, row mask,
  // and whether the original word is the expected answer (else the model).
  localparam logic [K-1:0]  V_DAT [NV] = '{25'h1555555, 25'h0ABCDEF, 25'h1F0F0F0, 25'h0123456, 25'h1FFFFFF,
                                           25'h0000000, 25'h1234567, 25'h0F0F0F0, 25'h1A2B3C4, 25'h0C3C3C3};
  localparam logic [K-1:0]  V_DFL [NV] = '{25'h0, 25'h0000001, 25'h0020008, 25'h0001000, 25'h0,
                                           25'h1000000, 25'h0000040, 25'h0000004, 25'h0100080, 25'h0000200};
  localparam logic [NC-1:0] V_CFL [NV] = '{20'h0, 20'h0, 20'h0, 20'h00020, 20'h80001,
                                           20'h0, 20'h0, 20'h0, 20'h00000, 20'h0};
  localparam logic [NC-1:0] V_MSK [NV] = '{20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF,
                                           20'h003FF, 20'h0001F, 20'h00000, 20'hA5A5A, 20'hFFC00};
  localparam bit            V_ORG [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam string         V_REQ [NV] = '{"R1", "R2", "R2", "R2", "R2", "R5", "R5", "R4", "R3", "R5"};

  function automatic bit member(input int i, input int j);
    int r, c, g, l;
    r = i / M; c = i % M; g = j / M; l = j % M;
    case (g)
      0:       return r == l;
      1:       return c == l;
      default: return ((r * (g - 1) + c) % M) == l;
    endcase
  endfunction

  function automatic logic [NC-1:0] encode(input logic [K-1:0] d);
    logic [NC-1:0] c;
    c = '0;
    for (int j = 0; j < NC; j++)
      for (int b = 0; b < K; b++)
        if (member(b, j)) c[j] = c[j] ^ d[b];
    return c;
  endfunction

  function automatic logic [NC-1:0] pack(input logic [NC-1:0] full, input logic [NC-1:0] en);
    logic [NC-1:0] st;
    int k;
    st = '0; k = 0;
    for (int j = 0; j < NC; j++)
      if (en[j]) begin st[k] = full[j]; k++; end
    return st;
  endfunction

  function automatic logic [K-1:0] model(input logic [K-1:0] d, input logic [NC-1:0] st,
                                         input logic [NC-1:0] en);
    logic [NC-1:0] full;
    logic [K-1:0]  res;
    int k;
    full = '0; k = 0;
    for (int j = 0; j < NC; j++)
      if (en[j]) begin full[j] = st[k]; k++; end
    for (int i = 0; i < K; i++) begin
      int ones, tot;
      ones = int'(d[i]); tot = 1;
      for (int j = 0; j < NC; j++) begin
        if (en[j] && member(i, j)) begin
          logic p;
          p = full[j];
          for (int b = 0; b < K; b++)
            if (b != i && member(b, j)) p = p ^ d[b];
          ones = ones + int'(p);
          tot  = tot + 1;
        end
      end
      if (2 * ones > tot)      res[i] = 1'b1;
      else if (2 * ones < tot) res[i] = 1'b0;
      else                     res[i] = d[i];
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [K-1:0] got, input logic [K-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: data_out=%h expected=%h", req, got, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic apply(input logic [K-1:0] d, input logic [NC-1:0] st, input logic [NC-1:0] en);
    @(negedge clk);
    data_in = d; chk_stored = st; row_en = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [K-1:0]  d, dc;
    logic [NC-1:0] full, en, st;
    rst_n = 1'b1;
    data_in = '0; chk_stored = '0; row_en = '0;
    #1 rst_n = 1'b0;
    data_in = 25'h1FFFFFF; chk_stored = encode(25'h1FFFFFF); row_en = '1;
    repeat (2) @(negedge clk);
    check("R6", data_out, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      full = encode(V_DAT[v]) ^ V_CFL[v];
      st   = pack(full, V_MSK[v]);
      dc   = V_DAT[v] ^ V_DFL[v];
      apply(dc, st, V_MSK[v]);
      check(V_REQ[v], data_out, V_ORG[v] ? V_DAT[v] : model(dc, st, V_MSK[v]));
    end

    // R5 tie: single group enabled, flipped bit keeps its raw value
    d = 25'h1234567;
    apply(d ^ 25'h40, pack(encode(d), 20'h0001F), 20'h0001F);
    check("R5", data_out, d ^ 25'h40);

    // R4: everything disabled, garbage check bits, corrupted word passes through
    apply(25'h0AAAAAA, 20'hFFFFF, '0);
    check("R4", data_out, 25'h0AAAAAA);

    // R3: bits above the enabled count carry garbage, result unchanged
    d = 25'h1357913; en = 20'h00F0F;
    st = pack(encode(d), en);
    apply(d ^ 25'h0000100, st | 20'hFFF00, en);
    check("R3", data_out, model(d ^ 25'h0000100, st, en));

    // R7: new input not visible before the edge, visible after it
    d = 25'h0F00F00;
    apply(d, encode(d), '1);
    @(negedge clk);
    data_in = 25'h00FF00F; chk_stored = encode(25'h00FF00F);
    #2;
    check("R7", data_out, d);
    @(posedge clk); #1;
    check("R7", data_out, 25'h00FF00F);

    // R8: held inputs keep the output steady
    @(negedge clk);
    @(negedge clk);
    check("R8", data_out, 25'h00FF00F);

    // R2: random words with up to T flips, all rows on
    for (int n = 0; n < 300; n++) begin
      d = K'($urandom);
      full = encode(d);
      dc = d;
      for (int f = 0; f < T; f++) begin
        int p;
        p = int'($urandom % (K + NC));
        if (p < K) dc[p] = ~dc[p];
        else full[p-K] = ~full[p-K];
      end
      apply(dc, full, '1);
      check("R2", data_out, d);
    end

    // R5: random masks and flips against the vote model
    for (int n = 0; n < 300; n++) begin
      d = K'($urandom);
      en = NC'($urandom);
      full = encode(d) ^ (NC'($urandom) & NC'($urandom) & NC'($urandom));
      dc = d ^ (K'($urandom) & K'($urandom) & K'($urandom));
      st = pack(full, en);
      apply(dc, st, en);
      check("R5", data_out, model(dc, st, en));
    end

    // R6: asynchronous reset in mid-run
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R6", data_out, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule